// File: doc/BRIEF.md
# Scan bridge test access port with instruction decoder

This block is the test access port of a scan bridge device. A standard five-signal style test port (test clock, mode select, data in, data out, asynchronous reset) drives a sixteen-state TAP controller. An 8-bit instruction register selects which data register sits between the serial input and the serial output. The data registers are a one-bit bypass, a 32-bit identification register, a 7-cell boundary register that only samples, two 8-bit configuration registers with held copies (port mode and multicast group), and two plain shift registers that stand in for a pattern generator and a clock counter.

Several instructions control ports rather than insert a register. These include unpark, three park variants, go-to-wait, soft reset, and the pattern-generator and counter on/off commands. Each one raises a single-cycle command pulse for the local-port logic. While such an instruction is current, the identification register is in the scan path. Every opcode that has no definition also selects the identification register. A `selected` input comes from the device addressing logic. When it is low, no command pulses are raised and the held configuration copies do not change. Scanning itself still works.

Top module: `scan_bridge_tap`

## Requirements
- R1: On `trst_n` low, and after any test-clock edge taken in Test-Logic-Reset, the current instruction is BYPASS (8'hFF). In that case all select strobes and command pulses are low and `tdo_en` is 0.
- R2: During Capture-IR the instruction shift register loads 8'h01, so the first eight bits scanned out of an instruction scan are 1,0,0,0,0,0,0,0 (least significant bit first).
- R3: Under BYPASS (8'hFF) the path is one cell that captures 0. An N-bit data scan returns 0 followed by the first N-1 input bits.
- R4: Under IDCODE (8'hAA) the 32-bit identification register captures 32'h0FC0E01F and shifts it out least significant bit first.
- R5: Under any opcode that is not one of 8'hFF, 8'h00, 8'h81, 8'h8E, 8'h03, 8'hC9 or 8'hCE, the 32-bit identification register is the scan path. This covers the port-control opcodes E7, C5, 84, C6, C3, 88, 0C, 8D, 0F and 90, and every undefined value.
- R6: SAMPLE/PRELOAD (8'h81) and EXTEST (8'h00) behave the same. A 7-bit path captures `sel_in[5:0]` in bits 0 to 5 and `oe_in` in bit 6. No cell drives any output.
- R7: MODESEL (8'h8E) puts an 8-bit mode shift register in the path. Capture-DR loads the held mode value. Update-DR copies the shifted value to `mode_q`, but only while `selected` is 1.
- R8: MCGRSEL (8'h03) does the same for the 8-bit multicast-group register and `group_q`. While `selected` is 0, Update-DR leaves `group_q` unchanged.
- R9: LFSRSEL (8'hC9) selects a 16-bit shift register and CNTRSEL (8'hCE) a 32-bit one. Neither changes on Capture-DR. Their contents appear on `lfsr_q` and `count_q`, and a scan returns the bits left by the previous scan.
- R10: On the clock edge taken in Update-IR with `selected` 1, the new opcode raises exactly one command pulse for one cycle. The mapping is E7 `unpark_o`, C5 `park_reset_o`, 84 `park_idle_o`, C6 `park_pause_o`, C3 `go_wait_o`, 88 `soft_rst_o`, 0C `lfsr_on_o`, 8D `lfsr_off_o`, 0F `cnt_on_o`, 90 `cnt_off_o`. With `selected` 0, or for any other opcode, no pulse is raised.
- R11: `sel_mode_o`, `sel_group_o`, `sel_lfsr_o` and `sel_cnt_o` are high exactly while the current instruction is 8E, 03, C9 or CE respectively.
- R12: `tdo` and `tdo_en` change on falling test-clock edges. `tdo_en` is 1 only in Shift-IR or Shift-DR; outside those states it is 0 and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| selected | input | 1 | Device is addressed; gates commands and held-copy updates |
| sel_in | input | 6 | Select inputs sampled by the boundary register |
| oe_in | input | 1 | Output-enable input sampled by the boundary register |
| tdo | output | 1 | Serial data out, falling-edge launched |
| tdo_en | output | 1 | Serial output enable |
| mode_q | output | 8 | Held port-mode value |
| group_q | output | 8 | Held multicast-group value |
| lfsr_q | output | 16 | Pattern-generator register contents |
| count_q | output | 32 | Clock-counter register contents |
| sel_mode_o | output | 1 | Mode register selected |
| sel_group_o | output | 1 | Multicast-group register selected |
| sel_lfsr_o | output | 1 | Pattern-generator register selected |
| sel_cnt_o | output | 1 | Counter register selected |
| unpark_o | output | 1 | Unpark command pulse |
| park_reset_o | output | 1 | Park-in-reset command pulse |
| park_idle_o | output | 1 | Park-in-idle command pulse |
| park_pause_o | output | 1 | Park-in-pause command pulse |
| go_wait_o | output | 1 | Go-to-wait command pulse |
| soft_rst_o | output | 1 | Soft-reset command pulse |
| lfsr_on_o | output | 1 | Pattern generator on pulse |
| lfsr_off_o | output | 1 | Pattern generator off pulse |
| cnt_on_o | output | 1 | Counter on pulse |
| cnt_off_o | output | 1 | Counter off pulse |

## Verification
Directed instruction scans with each register-selecting opcode and with each port-control opcode are run against random opcode bytes. This separates the seven path choices and shows that undefined values fall to the identification register rather than bypass. Random data words are scanned twice through each register. The second scan tells a register that captures its held copy or keeps its contents apart from one that reloads a constant. Toggling `selected` separates the scan path, which always works, from the command pulses and held-copy updates, which it suppresses. Random boundary inputs confirm the order of the cells.

// File: rtl/scan_bridge_pkg.sv
package scan_bridge_pkg;

   localparam int OP_W  = 8;
   localparam int CMD_N = 10;

   typedef enum logic [3:0] {
      ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR,
      ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_t;

   typedef enum logic [2:0] {
      DR_BYPASS, DR_BOUNDARY, DR_IDENT, DR_MODE, DR_GROUP, DR_LFSR, DR_COUNT
   } dr_sel_t;

   localparam logic [OP_W-1:0] OP_BYPASS     = 8'hFF;
   localparam logic [OP_W-1:0] OP_EXTEST     = 8'h00;
   localparam logic [OP_W-1:0] OP_SAMPLE     = 8'h81;
   localparam logic [OP_W-1:0] OP_IDCODE     = 8'hAA;
   localparam logic [OP_W-1:0] OP_UNPARK     = 8'hE7;
   localparam logic [OP_W-1:0] OP_PARK_RESET = 8'hC5;
   localparam logic [OP_W-1:0] OP_PARK_IDLE  = 8'h84;
   localparam logic [OP_W-1:0] OP_PARK_PAUSE = 8'hC6;
   localparam logic [OP_W-1:0] OP_GO_WAIT    = 8'hC3;
   localparam logic [OP_W-1:0] OP_MODE_SEL   = 8'h8E;
   localparam logic [OP_W-1:0] OP_GROUP_SEL  = 8'h03;
   localparam logic [OP_W-1:0] OP_SOFT_RST   = 8'h88;
   localparam logic [OP_W-1:0] OP_LFSR_SEL   = 8'hC9;
   localparam logic [OP_W-1:0] OP_LFSR_ON    = 8'h0C;
   localparam logic [OP_W-1:0] OP_LFSR_OFF   = 8'h8D;
   localparam logic [OP_W-1:0] OP_CNT_SEL    = 8'hCE;
   localparam logic [OP_W-1:0] OP_CNT_ON     = 8'h0F;
   localparam logic [OP_W-1:0] OP_CNT_OFF    = 8'h90;

   localparam int CMD_UNPARK     = 0;
   localparam int CMD_PARK_RESET = 1;
   localparam int CMD_PARK_IDLE  = 2;
   localparam int CMD_PARK_PAUSE = 3;
   localparam int CMD_GO_WAIT    = 4;
   localparam int CMD_SOFT_RST   = 5;
   localparam int CMD_LFSR_ON    = 6;
   localparam int CMD_LFSR_OFF   = 7;
   localparam int CMD_CNT_ON     = 8;
   localparam int CMD_CNT_OFF    = 9;

   function automatic dr_sel_t dr_for_op(input logic [OP_W-1:0] op);
      case (op)
         OP_BYPASS:             return DR_BYPASS;
         OP_EXTEST, OP_SAMPLE:  return DR_BOUNDARY;
         OP_MODE_SEL:           return DR_MODE;
         OP_GROUP_SEL:          return DR_GROUP;
         OP_LFSR_SEL:           return DR_LFSR;
         OP_CNT_SEL:            return DR_COUNT;
         default:               return DR_IDENT;
      endcase
   endfunction

   function automatic logic [CMD_N-1:0] cmd_for_op(input logic [OP_W-1:0] op);
      logic [CMD_N-1:0] v;
      v = '0;
      case (op)
         OP_UNPARK:     v[CMD_UNPARK]     = 1'b1;
         OP_PARK_RESET: v[CMD_PARK_RESET] = 1'b1;
         OP_PARK_IDLE:  v[CMD_PARK_IDLE]  = 1'b1;
         OP_PARK_PAUSE: v[CMD_PARK_PAUSE] = 1'b1;
         OP_GO_WAIT:    v[CMD_GO_WAIT]    = 1'b1;
         OP_SOFT_RST:   v[CMD_SOFT_RST]   = 1'b1;
         OP_LFSR_ON:    v[CMD_LFSR_ON]    = 1'b1;
         OP_LFSR_OFF:   v[CMD_LFSR_OFF]   = 1'b1;
         OP_CNT_ON:     v[CMD_CNT_ON]     = 1'b1;
         OP_CNT_OFF:    v[CMD_CNT_OFF]    = 1'b1;
         default:       v = '0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/scan_bridge_fsm.sv
module scan_bridge_fsm
   import scan_bridge_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state
);

   tap_state_t nxt;

   always_comb begin
      case (state)
         ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
         ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
         ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
         ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
         default:   nxt = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_TLR;
      else         state <= nxt;
   end

   // R1
   tlr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_TLR && tms) |=> state == ST_TLR);

   // R12
   shift_ir_entry_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_SH_IR) |-> ($past(state) == ST_CAP_IR || $past(state) == ST_SH_IR
                               || $past(state) == ST_EX2_IR));

endmodule

// File: rtl/scan_bridge_ir.sv
module scan_bridge_ir
   import scan_bridge_pkg::*;
#(
   parameter int              IR_W     = 8,
   parameter logic [IR_W-1:0] CAP_PAT  = 8'h01,
   parameter logic [IR_W-1:0] RESET_OP = 8'hFF
)(
   input  logic             tck,
   input  logic             trst_n,
   input  tap_state_t       state,
   input  logic             tdi,
   input  logic             selected,
   output logic             so,
   output logic [IR_W-1:0]  ir_q,
   output logic [CMD_N-1:0] cmd_q
);

   if (IR_W != OP_W) begin : g_bad_width
      $error("scan_bridge_ir: IR_W must equal the opcode width");
   end
   if (CAP_PAT[1:0] != 2'b01) begin : g_bad_pat
      $error("scan_bridge_ir: capture pattern must end in 01");
   end

   logic [IR_W-1:0] sh_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sh_q  <= CAP_PAT;
         ir_q  <= RESET_OP;
         cmd_q <= '0;
      end else begin
         if (state == ST_CAP_IR)     sh_q <= CAP_PAT;
         else if (state == ST_SH_IR) sh_q <= {tdi, sh_q[IR_W-1:1]};

         if (state == ST_TLR)        ir_q <= RESET_OP;
         else if (state == ST_UPD_IR) ir_q <= sh_q;

         if (state == ST_UPD_IR && selected) cmd_q <= cmd_for_op(sh_q);
         else                                cmd_q <= '0;
      end
   end

   assign so = sh_q[0];

   // R1
   tlr_bypass_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_TLR) |=> ir_q == RESET_OP);

   // R10
   cmd_single_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0(cmd_q));

endmodule

// File: rtl/scan_bridge_dreg.sv
module scan_bridge_dreg
   import scan_bridge_pkg::*;
#(
   parameter int W      = 8,
   parameter bit SHADOW = 1'b1
)(
   input  logic         tck,
   input  logic         trst_n,
   input  tap_state_t   state,
   input  logic         active,
   input  logic         upd_en,
   input  logic         tdi,
   output logic         so,
   output logic [W-1:0] val_q
);

   if (W < 2) begin : g_bad_w
      $error("scan_bridge_dreg: W must be at least 2");
   end

   logic [W-1:0] sh_q;
   logic         shift_c;

   assign shift_c = active && (state == ST_SH_DR);
   assign so      = sh_q[0];

   if (SHADOW) begin : g_shadow
      logic [W-1:0] shadow_q;
      logic         cap_c;
      logic         upd_c;

      assign cap_c = active && (state == ST_CAP_DR);
      assign upd_c = active && (state == ST_UPD_DR) && upd_en;

      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n) begin
            sh_q     <= '0;
            shadow_q <= '0;
         end else begin
            if (cap_c)        sh_q <= shadow_q;
            else if (shift_c) sh_q <= {tdi, sh_q[W-1:1]};
            if (upd_c)        shadow_q <= sh_q;
         end
      end

      assign val_q = shadow_q;

      // R7
      shadow_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
         !upd_c |=> $stable(shadow_q));
   end else begin : g_hold
      logic unused_upd;
      assign unused_upd = upd_en;

      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n)      sh_q <= '0;
         else if (shift_c) sh_q <= {tdi, sh_q[W-1:1]};
      end

      assign val_q = sh_q;

      // R9
      hold_stable_chk: assert property (@(posedge tck) disable iff (!trst_n)
         !shift_c |=> $stable(sh_q));
   end

endmodule

// File: rtl/scan_bridge_tap.sv
module scan_bridge_tap
   import scan_bridge_pkg::*;
#(
   parameter int               IR_W     = 8,
   parameter logic [31:0]      ID_VALUE = 32'h0FC0E01F,
   parameter int               N_SEL    = 6,
   parameter int               MODE_W   = 8,
   parameter int               GROUP_W  = 8,
   parameter int               LFSR_W   = 16,
   parameter int               CNT_W    = 32
)(
   input  logic               tck,
   input  logic               trst_n,
   input  logic               tms,
   input  logic               tdi,
   input  logic               selected,
   input  logic [N_SEL-1:0]   sel_in,
   input  logic               oe_in,
   output logic               tdo,
   output logic               tdo_en,
   output logic [MODE_W-1:0]  mode_q,
   output logic [GROUP_W-1:0] group_q,
   output logic [LFSR_W-1:0]  lfsr_q,
   output logic [CNT_W-1:0]   count_q,
   output logic               sel_mode_o,
   output logic               sel_group_o,
   output logic               sel_lfsr_o,
   output logic               sel_cnt_o,
   output logic               unpark_o,
   output logic               park_reset_o,
   output logic               park_idle_o,
   output logic               park_pause_o,
   output logic               go_wait_o,
   output logic               soft_rst_o,
   output logic               lfsr_on_o,
   output logic               lfsr_off_o,
   output logic               cnt_on_o,
   output logic               cnt_off_o
);

   localparam int BSR_W = N_SEL + 1;
   localparam int ID_W  = 32;

   if (ID_VALUE[0] != 1'b1) begin : g_bad_id
      $error("scan_bridge_tap: identification value must have bit 0 set");
   end
   if (N_SEL < 1) begin : g_bad_sel
      $error("scan_bridge_tap: N_SEL must be at least 1");
   end

   tap_state_t       state;
   logic [IR_W-1:0]  ir_q;
   logic [CMD_N-1:0] cmd_q;
   logic             ir_so;
   dr_sel_t          dsel;

   scan_bridge_fsm u_fsm (
      .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
   );

   scan_bridge_ir #(.IR_W(IR_W)) u_ir (
      .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
      .selected(selected), .so(ir_so), .ir_q(ir_q), .cmd_q(cmd_q)
   );

   assign dsel = dr_for_op(ir_q);

   // fixed-content registers: bypass, identification, boundary
   logic             byp_q;
   logic [ID_W-1:0]  id_sh;
   logic [BSR_W-1:0] bsr_sh;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         byp_q  <= 1'b0;
         id_sh  <= ID_VALUE;
         bsr_sh <= '0;
      end else if (state == ST_CAP_DR) begin
         case (dsel)
            DR_BYPASS:   byp_q  <= 1'b0;
            DR_IDENT:    id_sh  <= ID_VALUE;
            DR_BOUNDARY: bsr_sh <= {oe_in, sel_in};
            default: ;
         endcase
      end else if (state == ST_SH_DR) begin
         case (dsel)
            DR_BYPASS:   byp_q  <= tdi;
            DR_IDENT:    id_sh  <= {tdi, id_sh[ID_W-1:1]};
            DR_BOUNDARY: bsr_sh <= {tdi, bsr_sh[BSR_W-1:1]};
            default: ;
         endcase
      end
   end

   // configurable registers
   logic mode_so, group_so, lfsr_so, cnt_so;

   assign sel_mode_o  = (dsel == DR_MODE);
   assign sel_group_o = (dsel == DR_GROUP);
   assign sel_lfsr_o  = (dsel == DR_LFSR);
   assign sel_cnt_o   = (dsel == DR_COUNT);

   scan_bridge_dreg #(.W(MODE_W), .SHADOW(1'b1)) u_mode (
      .tck(tck), .trst_n(trst_n), .state(state), .active(sel_mode_o),
      .upd_en(selected), .tdi(tdi), .so(mode_so), .val_q(mode_q)
   );

   scan_bridge_dreg #(.W(GROUP_W), .SHADOW(1'b1)) u_group (
      .tck(tck), .trst_n(trst_n), .state(state), .active(sel_group_o),
      .upd_en(selected), .tdi(tdi), .so(group_so), .val_q(group_q)
   );

   scan_bridge_dreg #(.W(LFSR_W), .SHADOW(1'b0)) u_lfsr (
      .tck(tck), .trst_n(trst_n), .state(state), .active(sel_lfsr_o),
      .upd_en(selected), .tdi(tdi), .so(lfsr_so), .val_q(lfsr_q)
   );

   scan_bridge_dreg #(.W(CNT_W), .SHADOW(1'b0)) u_cnt (
      .tck(tck), .trst_n(trst_n), .state(state), .active(sel_cnt_o),
      .upd_en(selected), .tdi(tdi), .so(cnt_so), .val_q(count_q)
   );

   // serial output select and falling-edge launch
   logic dr_so;

   always_comb begin
      case (dsel)
         DR_BYPASS:   dr_so = byp_q;
         DR_BOUNDARY: dr_so = bsr_sh[0];
         DR_MODE:     dr_so = mode_so;
         DR_GROUP:    dr_so = group_so;
         DR_LFSR:     dr_so = lfsr_so;
         DR_COUNT:    dr_so = cnt_so;
         default:     dr_so = id_sh[0];
      endcase
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else if (state == ST_SH_IR) begin
         tdo    <= ir_so;
         tdo_en <= 1'b1;
      end else if (state == ST_SH_DR) begin
         tdo    <= dr_so;
         tdo_en <= 1'b1;
      end else begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end
   end

   assign unpark_o     = cmd_q[CMD_UNPARK];
   assign park_reset_o = cmd_q[CMD_PARK_RESET];
   assign park_idle_o  = cmd_q[CMD_PARK_IDLE];
   assign park_pause_o = cmd_q[CMD_PARK_PAUSE];
   assign go_wait_o    = cmd_q[CMD_GO_WAIT];
   assign soft_rst_o   = cmd_q[CMD_SOFT_RST];
   assign lfsr_on_o    = cmd_q[CMD_LFSR_ON];
   assign lfsr_off_o   = cmd_q[CMD_LFSR_OFF];
   assign cnt_on_o     = cmd_q[CMD_CNT_ON];
   assign cnt_off_o    = cmd_q[CMD_CNT_OFF];

   // R10
   cmd_from_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (|cmd_q) |-> ($past(state) == ST_UPD_IR && $past(selected)));

   // R10
   cmd_one_cycle_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (|cmd_q) |=> (cmd_q == '0));

   // R11
   sel_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({sel_mode_o, sel_group_o, sel_lfsr_o, sel_cnt_o}));

   // R6
   boundary_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAP_DR && dsel == DR_BOUNDARY) |=> bsr_sh == $past({oe_in, sel_in}));

endmodule

// File: tb/scan_bridge_tap_bench.sv
`timescale 1ns/1ps
module scan_bridge_tap_bench;

   logic        tck = 1'b0;
   logic        trst_n, tms, tdi, selected, oe_in;
   logic [5:0]  sel_in;
   logic        tdo, tdo_en;
   logic [7:0]  mode_q, group_q;
   logic [15:0] lfsr_q;
   logic [31:0] count_q;
   logic        sel_mode_o, sel_group_o, sel_lfsr_o, sel_cnt_o;
   logic        unpark_o, park_reset_o, park_idle_o, park_pause_o, go_wait_o;
   logic        soft_rst_o, lfsr_on_o, lfsr_off_o, cnt_on_o, cnt_off_o;
   logic [9:0]  cmd_v;
   logic [3:0]  sel_v;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 tck = ~tck;

   scan_bridge_tap u_scan_bridge_tap (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .selected(selected),
      .sel_in(sel_in), .oe_in(oe_in), .tdo(tdo), .tdo_en(tdo_en),
      .mode_q(mode_q), .group_q(group_q), .lfsr_q(lfsr_q), .count_q(count_q),
      .sel_mode_o(sel_mode_o), .sel_group_o(sel_group_o),
      .sel_lfsr_o(sel_lfsr_o), .sel_cnt_o(sel_cnt_o),
      .unpark_o(unpark_o), .park_reset_o(park_reset_o), .park_idle_o(park_idle_o),
      .park_pause_o(park_pause_o), .go_wait_o(go_wait_o), .soft_rst_o(soft_rst_o),
      .lfsr_on_o(lfsr_on_o), .lfsr_off_o(lfsr_off_o),
      .cnt_on_o(cnt_on_o), .cnt_off_o(cnt_off_o)
   );

   assign cmd_v = {cnt_off_o, cnt_on_o, lfsr_off_o, lfsr_on_o, soft_rst_o,
                   go_wait_o, park_pause_o, park_idle_o, park_reset_o, unpark_o};
   assign sel_v = {sel_cnt_o, sel_lfsr_o, sel_group_o, sel_mode_o};

   localparam logic [31:0] ID = 32'h0FC0E01F;
   localparam logic [7:0] OPS [18] = '{8'hFF, 8'h00, 8'h81, 8'hAA, 8'hE7, 8'hC5,
      8'h84, 8'hC6, 8'hC3, 8'h8E, 8'h03, 8'h88, 8'hC9, 8'h0C, 8'h8D, 8'hCE, 8'h0F, 8'h90};
   localparam logic [7:0] CTL [10] = '{8'hE7, 8'hC5, 8'h84, 8'hC6, 8'hC3,
      8'h88, 8'h0C, 8'h8D, 8'h0F, 8'h90};

   function automatic logic [9:0] exp_cmd(input logic [7:0] op, input logic sel);
      logic [9:0] v;
      v = '0;
      for (int i = 0; i < 10; i++) if (CTL[i] == op) v[i] = 1'b1;
      return sel ? v : 10'd0;
   endfunction

   function automatic int exp_len(input logic [7:0] op);
      case (op)
         8'hFF:        return 1;
         8'h00, 8'h81: return 7;
         8'h8E, 8'h03: return 8;
         8'hC9:        return 16;
         default:      return 32;
      endcase
   endfunction

   function automatic logic [3:0] exp_sel(input logic [7:0] op);
      case (op)
         8'h8E:   return 4'b0001;
         8'h03:   return 4'b0010;
         8'hC9:   return 4'b0100;
         8'hCE:   return 4'b1000;
         default: return 4'b0000;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d);
      tms = m;
      tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   // from Run-Test/Idle; returns captured bits, pulses after update, pulses one cycle later
   task automatic ir_scan(input logic [7:0] op, output logic [7:0] cap,
                          output logic [9:0] pls, output logic [9:0] pls_after);
      cap = '0;
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      chk("R12 tdo_en in Shift-IR", {31'd0, tdo_en}, 32'd1);
      for (int i = 0; i < 8; i++) begin
         cap[i] = tdo;
         step(i == 7, op[i]);
      end
      step(1, 0);
      step(0, 0);
      pls = cmd_v;
      step(0, 0);
      pls_after = cmd_v;
   endtask

   task automatic dr_scan(input int n, input logic [31:0] d, output logic [31:0] q);
      q = '0;
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < n; i++) begin
         q[i] = tdo;
         step(i == n - 1, d[i]);
      end
      step(1, 0);
      step(0, 0);
   endtask

   function automatic logic [31:0] mask(input int n);
      return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
   endfunction

   initial begin
      repeat (200000) @(posedge tck);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0]  cap, op;
      logic [9:0]  pls, pla;
      logic [31:0] q, d, e;
      logic [7:0]  m_mode, m_group;
      logic [15:0] m_lfsr;
      logic [31:0] m_cnt;
      int          len;

      void'($urandom(32'd20240917));
      trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; selected = 1'b1;
      sel_in = 6'd0; oe_in = 1'b0;
      m_mode = '0; m_group = '0; m_lfsr = '0; m_cnt = '0;
      repeat (3) @(posedge tck);
      @(negedge tck); #1;

      // R1 reset state
      chk("R1 tdo_en after reset", {31'd0, tdo_en}, 32'd0);
      chk("R1 pulses after reset", {22'd0, cmd_v}, 32'd0);
      chk("R1 selects after reset", {28'd0, sel_v}, 32'd0);
      chk("R1 mode after reset", {24'd0, mode_q}, 32'd0);
      trst_n = 1'b1;
      step(1, 0);
      step(0, 0);
      chk("R12 tdo_en idle", {30'd0, tdo_en, tdo}, 32'd0);

      // R3 bypass from reset, one-cell delay
      d = 32'h000000B5;
      dr_scan(8, d, q);
      chk("R3 bypass after reset", q & 32'hFF, {24'd0, d[6:0], 1'b0});

      // R2 capture pattern, R4 identification
      ir_scan(8'hAA, cap, pls, pla);
      chk("R2 IR capture", {24'd0, cap}, 32'h01);
      chk("R10 IDCODE no pulse", {22'd0, pls}, 32'd0);
      dr_scan(32, 32'h0, q);
      chk("R4 IDCODE value", q, ID);

      // R6 boundary order, both opcodes
      sel_in = 6'b101001; oe_in = 1'b1;
      ir_scan(8'h81, cap, pls, pla);
      dr_scan(7, 32'h0, q);
      chk("R6 SAMPLE capture", q & 32'h7F, {25'd0, 1'b1, 6'b101001});
      sel_in = 6'b010110; oe_in = 1'b0;
      ir_scan(8'h00, cap, pls, pla);
      dr_scan(7, 32'h7F, q);
      chk("R6 EXTEST capture", q & 32'h7F, {25'd0, 1'b0, 6'b010110});

      // R10 and R5 every port-control opcode
      for (int i = 0; i < 10; i++) begin
         ir_scan(CTL[i], cap, pls, pla);
         chk("R10 pulse on update", {22'd0, pls}, {22'd0, exp_cmd(CTL[i], 1'b1)});
         chk("R10 pulse one cycle", {22'd0, pla}, 32'd0);
         dr_scan(32, $urandom, q);
         chk("R5 control opcode path", q, ID);
      end

      // R10 not selected: no pulse
      selected = 1'b0;
      ir_scan(8'hE7, cap, pls, pla);
      chk("R10 unselected no pulse", {22'd0, pls}, 32'd0);
      selected = 1'b1;

      // R7 mode write, readback, unselected ignore; R11 strobe
      ir_scan(8'h8E, cap, pls, pla);
      chk("R11 mode strobe", {28'd0, sel_v}, 32'b0001);
      d = {24'd0, 8'h5C};
      dr_scan(8, d, q);
      chk("R7 mode update", {24'd0, mode_q}, 32'h5C);
      dr_scan(8, 32'hA3, q);
      chk("R7 mode readback", q & 32'hFF, 32'h5C);
      chk("R7 mode second update", {24'd0, mode_q}, 32'hA3);
      m_mode = 8'hA3;
      selected = 1'b0;
      dr_scan(8, 32'h11, q);
      chk("R7 mode unselected ignored", {24'd0, mode_q}, 32'hA3);
      selected = 1'b1;
      dr_scan(8, 32'hA3, q);
      chk("R7 mode shadow kept", q & 32'hFF, 32'hA3);

      // R8 group register
      ir_scan(8'h03, cap, pls, pla);
      chk("R11 group strobe", {28'd0, sel_v}, 32'b0010);
      dr_scan(8, 32'h96, q);
      chk("R8 group update", {24'd0, group_q}, 32'h96);
      selected = 1'b0;
      dr_scan(8, 32'h69, q);
      chk("R8 group unselected readback", q & 32'hFF, 32'h96);
      chk("R8 group unselected ignored", {24'd0, group_q}, 32'h96);
      selected = 1'b1;
      m_group = 8'h96;

      // R9 plain shift registers
      ir_scan(8'hC9, cap, pls, pla);
      chk("R11 lfsr strobe", {28'd0, sel_v}, 32'b0100);
      dr_scan(16, 32'hBEEF, q);
      chk("R9 lfsr contents", {16'd0, lfsr_q}, 32'hBEEF);
      dr_scan(16, 32'h1234, q);
      chk("R9 lfsr readback", q & 32'hFFFF, 32'hBEEF);
      m_lfsr = 16'h1234;
      ir_scan(8'hCE, cap, pls, pla);
      chk("R11 counter strobe", {28'd0, sel_v}, 32'b1000);
      dr_scan(32, 32'hCAFE0123, q);
      chk("R9 counter contents", count_q, 32'hCAFE0123);
      m_cnt = 32'hCAFE0123;

      // R1 logic reset by tms, instruction returns to bypass
      for (int i = 0; i < 5; i++) step(1, 0);
      step(0, 0);
      chk("R1 tms reset selects", {28'd0, sel_v}, 32'd0);
      dr_scan(4, 32'hF, q);
      chk("R1 tms reset bypass", q & 32'hF, 32'hE);
      chk("R9 counter kept over reset", count_q, m_cnt);

      // random opcodes and data
      for (int it = 0; it < 60; it++) begin
         if ($urandom % 2) op = OPS[$urandom % 18];
         else              op = 8'($urandom);
         selected = 1'($urandom);
         sel_in = 6'($urandom);
         oe_in = 1'($urandom);
         d = $urandom;
         ir_scan(op, cap, pls, pla);
         chk("R2 random IR capture", {24'd0, cap}, 32'h01);
         chk("R10 random pulse", {22'd0, pls}, {22'd0, exp_cmd(op, selected)});
         chk("R11 random strobe", {28'd0, sel_v}, {28'd0, exp_sel(op)});
         len = exp_len(op);
         case (op)
            8'hFF:        e = {31'd0, 1'b0};
            8'h00, 8'h81: e = {25'd0, oe_in, sel_in};
            8'h8E:        e = {24'd0, m_mode};
            8'h03:        e = {24'd0, m_group};
            8'hC9:        e = {16'd0, m_lfsr};
            8'hCE:        e = m_cnt;
            default:      e = ID;
         endcase
         dr_scan(len, d, q);
         case (op)
            8'hFF:        chk("R3 random bypass", q & mask(len), e);
            8'h00, 8'h81: chk("R6 random boundary", q & mask(len), e);
            8'h8E:        chk("R7 random mode", q & mask(len), e);
            8'h03:        chk("R8 random group", q & mask(len), e);
            8'hC9, 8'hCE: chk("R9 random shift reg", q & mask(len), e);
            8'hAA:        chk("R4 random idcode", q, e);
            default:      chk("R5 random ident path", q, e);
         endcase
         if (op == 8'h8E && selected) m_mode  = d[7:0];
         if (op == 8'h03 && selected) m_group = d[7:0];
         if (op == 8'hC9) m_lfsr = d[15:0];
         if (op == 8'hCE) m_cnt  = d;
         chk("R7 random mode held", {24'd0, mode_q}, {24'd0, m_mode});
         chk("R8 random group held", {24'd0, group_q}, {24'd0, m_group});
         chk("R12 random idle enable", {31'd0, tdo_en}, 32'd0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule